// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that an SDRAM read or write burst touches. A controller supplies a start column, a length code and an ordering bit, and pulses a start strobe while the generator is idle. From the next cycle on, the generator presents one column per beat on a valid/ready output stream. It marks the final beat with a done flag and then goes idle again.

For fixed lengths every beat stays inside a block of columns aligned to the burst length. The upper column bits come unchanged from the start column. The low bits step in either linear (wrapping) order or XOR order. A full-page burst walks the whole row with wrap at the row end. It has no length of its own and stops only when a terminate request arrives, so the controller can cut off a burst of any length. A terminate request also cuts a fixed-length burst short.

Back-pressure rules: a beat counts as consumed only in a cycle where both `col_valid` and `col_ready` are high. While `col_ready` is low, the presented column and the valid flag stay unchanged. `done` is high only together with `col_valid`, on the beat that ends the burst. The burst is over once that beat is consumed.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and in the first idle cycles after reset, `col_valid` and `done` are low.
- R2: A `start` pulse seen at a clock edge while idle makes `col_valid` rise after that edge, with `col_out` equal to the captured `start_col` on the first beat.
- R3: `len_code` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The reserved codes 4, 5 and 6 behave as length 1.
- R4: With `burst_type` = 0 and length L ≤ 8, the low log2(L) bits of beat n equal (start low bits + n) mod L. The upper bits equal those of `start_col`.
- R5: With `burst_type` = 1 and length L ≤ 8, the low log2(L) bits of beat n equal (start low bits XOR n). The upper bits equal those of `start_col`.
- R6: A full-page burst outputs (start_col + n) mod 256 whatever `burst_type` is. It continues until a terminate request.
- R7: When `terminate` is high while a beat is presented, that beat is the last one: `done` is high with it, and the burst ends when it is consumed.
- R8: `done` is high only with `col_valid`, and only on the final beat. After the final beat is consumed, `col_valid` is low in the next cycle.
- R9: While `col_valid` is high and `col_ready` is low, `col_out` and `col_valid` hold their values and no beat is consumed.
- R10: A `start` pulse while a burst is active is ignored. The sequence in progress is unchanged and no new burst begins when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request strobe, taken only when idle |
| start_col | input | 8 | Starting column of the burst |
| len_code | input | 3 | Burst length code (see R3) |
| burst_type | input | 1 | 0 = linear order, 1 = XOR order |
| terminate | input | 1 | End the burst on the presented beat |
| col_ready | input | 1 | Consumer accepts the presented beat |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented |
| done | output | 1 | Presented beat is the last of the burst |

## Verification
Two events can fall on the same beat: the natural end of a fixed-length burst and an early terminate request. Both also meet back-pressure. The bench provokes the overlap by raising `terminate` on randomly chosen beat indices, including the last index, while `col_ready` is withheld at random. A start strobe is also pulsed during the final beat. In every cycle, the presented column and `done` are compared with a bench model built from R3–R7. After each burst, the bench confirms that the stream goes quiet and that no stray burst was launched.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    LEN_ONE   = 3'd0,
    LEN_TWO   = 3'd1,
    LEN_FOUR  = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE  = 3'd7
  } len_code_e;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  output logic [COL_W-1:0] blk_mask,
  output logic             page_mode
);
  import colgen_pkg::*;

  always_comb begin
    blk_mask  = '0;
    page_mode = 1'b0;
    case (len_code_e'(len_code))
      LEN_TWO:   blk_mask = COL_W'(1);
      LEN_FOUR:  blk_mask = COL_W'(3);
      LEN_EIGHT: blk_mask = COL_W'(7);
      LEN_PAGE: begin
        blk_mask  = '1;
        page_mode = 1'b1;
      end
      default:   blk_mask = '0;
    endcase
  end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             page_in,
  input  logic             order_in,
  input  logic             terminate,
  input  logic             take,
  output logic             busy,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             xor_q,
  output logic [COL_W-1:0] beat_q,
  output logic             last_beat
);
  logic page_q;

  assign last_beat = terminate || (!page_q && (beat_q == mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      xor_q  <= 1'b0;
      beat_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        base_q <= start_col;
        mask_q <= mask_in;
        page_q <= page_in;
        xor_q  <= order_in & ~page_in;
        beat_q <= '0;
      end
    end else if (take) begin
      if (last_beat) busy <= 1'b0;
      else           beat_q <= beat_q + COL_W'(1);
    end
  end
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] beat,
  input  logic             use_xor,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] lin_step;
  logic [COL_W-1:0] xor_step;
  logic [COL_W-1:0] pick;

  assign lin_step = base + beat;
  assign xor_step = base ^ beat;
  assign pick     = use_xor ? xor_step : lin_step;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = mask[i] ? pick[i] : base[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             burst_type,
  input  logic             terminate,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             done
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             busy;
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             xor_q, last_beat;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .blk_mask (dec_mask),
    .page_mode(dec_page)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_col(start_col),
    .mask_in  (dec_mask),
    .page_in  (dec_page),
    .order_in (burst_type),
    .terminate(terminate),
    .take     (col_ready),
    .busy     (busy),
    .base_q   (base_q),
    .mask_q   (mask_q),
    .xor_q    (xor_q),
    .beat_q   (beat_q),
    .last_beat(last_beat)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base   (base_q),
    .mask   (mask_q),
    .beat   (beat_q),
    .use_xor(xor_q),
    .col    (col_out)
  );

  assign col_valid = busy;
  assign done      = busy & last_beat;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             terminate,
  input logic             col_ready,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !col_valid && !done);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid && start |=> col_valid && col_out == $past(start_col));

  // R8
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> col_valid);

  // R8
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && col_ready |=> !col_valid);

  // R7
  term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && terminate |=> !col_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |=> col_valid && $stable(col_out));

  // R10
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !(done && col_ready) |=> col_valid);
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .terminate(terminate), .col_ready(col_ready), .col_out(col_out),
  .col_valid(col_valid), .done(done)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       burst_type = 1'b0;
  logic       terminate = 1'b0;
  logic       col_ready = 1'b0;
  logic [7:0] col_out;
  logic       col_valid, done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .burst_type(burst_type), .terminate(terminate),
    .col_ready(col_ready), .col_out(col_out), .col_valid(col_valid), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic int burst_len(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                         input logic typ, input int n);
    int   len  = burst_len(code);
    int   msk  = len - 1;
    int   low;
    if (typ && code != 3'd7) low = int'(s) ^ n;
    else                     low = int'(s) + n;
    return 8'(((int'(s) & ~msk) | (low & msk)) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // term_beat < 0 means no terminate request
  task automatic run_burst(input logic [7:0] s, input logic [2:0] code, input logic typ,
                           input int term_beat, input int ready_pct, input bit spam);
    int  k = 0;
    bit  fin = 0;
    int  len = burst_len(code);
    string tag;
    @(negedge clk);
    start = 1; start_col = s; len_code = code; burst_type = typ;
    terminate = 0; col_ready = 0;
    @(negedge clk);
    start = 0;
    while (!fin) begin
      logic [7:0] e;
      bit rdy = ($urandom % 100) < ready_pct;
      bit trm = (k == term_beat);
      bit edn;
      col_ready = rdy;
      terminate = trm;
      if (spam) begin
        start = 1'($urandom); start_col = 8'($urandom); len_code = 3'($urandom);
        burst_type = 1'($urandom);
      end
      #1;
      e   = exp_col(s, code, typ, k);
      edn = trm || (len != 256 && k == len - 1);
      if (trm) tag = "R7";
      else if (code == 3'd7) tag = "R6";
      else if (code > 3'd3) tag = "R3";
      else if (typ) tag = "R5";
      else tag = "R4";
      if (k == 0) tag = {tag, "/R2"};
      if (spam) tag = {tag, "/R10"};
      if (!rdy) tag = {tag, "/R9"};
      check(col_valid === 1'b1, tag, "valid", int'(col_valid), 1);
      check(col_out === e, tag, "col", int'(col_out), int'(e));
      check(done === edn, {tag, "/R8"}, "done", int'(done), int'(edn));
      @(negedge clk);
      start = 0;
      if (rdy) begin
        if (edn) fin = 1;
        k++;
      end
    end
    terminate = 0; col_ready = 0;
    #1;
    check(col_valid === 1'b0, spam ? "R10" : "R8", "idle valid", int'(col_valid), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c01));
    repeat (3) @(negedge clk);
    check(col_valid === 1'b0, "R1", "reset valid", int'(col_valid), 0);
    check(done === 1'b0, "R1", "reset done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    check(col_valid === 1'b0, "R1", "post-reset valid", int'(col_valid), 0);

    // directed corners
    run_burst(8'h0E, 3'd3, 1'b0, -1, 100, 0);   // R4 wrap in block of 8
    run_burst(8'h05, 3'd3, 1'b1, -1, 100, 0);   // R5 xor order
    run_burst(8'h13, 3'd2, 1'b1, -1, 60, 0);    // R5 length 4
    run_burst(8'hFE, 3'd7, 1'b0, 3, 100, 0);    // R6 wrap past row end
    run_burst(8'hFE, 3'd7, 1'b1, 5, 50, 0);     // R6 type ignored
    run_burst(8'h47, 3'd5, 1'b1, -1, 100, 0);   // R3 reserved code
    run_burst(8'h33, 3'd0, 1'b0, -1, 40, 0);    // R3 length 1
    run_burst(8'h0B, 3'd3, 1'b0, 7, 50, 1);     // R7 terminate on natural last
    run_burst(8'h09, 3'd3, 1'b1, 2, 70, 1);     // R7 early terminate, R10
    run_burst(8'h81, 3'd1, 1'b0, -1, 100, 1);   // R10 start during burst

    for (int i = 0; i < 400; i++) begin
      logic [2:0] c = 3'($urandom);
      int tb;
      if (c == 3'd7) tb = 1 + int'($urandom % 300);
      else if ($urandom % 3 == 0) tb = int'($urandom % 8);
      else tb = -1;
      run_burst(8'($urandom), c, 1'($urandom), tb, 30 + int'($urandom % 71),
                1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule